// File: doc/BRIEF.md
# Redundant Clock Source Divergence Monitor

This block watches three nominally identical clock sources that stand in for one clock generator. Each source clocks its own free-running counter. The counter is held as three voted copies, so a single upset in counter state cannot look like a clock fault. Each counter value is Gray-encoded, carried into the reference domain through a two-stage synchronizer and decoded back to binary. The three views are then compared in pairs, each pair within a tolerance of plus or minus two counts.

When one source's count disagrees with the other two for four reference samples in a row, that source is named faulty. Its fault flag latches and its reset request pulses for eight reference cycles. All three counters are then cleared together and comparison starts again. If all three pairs disagree, no single source can be blamed. A separate unresolvable flag latches instead, and no reset is requested. Recovery acts by reset alone: repairing a source's internals is outside this block.

Top module: `clk_divergence_monitor`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `fault_o`, `rst_req_o` and `multi_fault_o` are all 0.
- R2: Three sources at the same frequency but different phases raise no fault and no reset request, because pairwise differences stay within plus or minus 2 counts.
- R3: A source whose count falls behind or runs ahead of the other two has its own bit of `fault_o` set. Bit i stands for `src_clk[i]`.
- R4: A fault is declared only after the same single-source mismatch has been seen for 4 consecutive reference samples. No flag appears within 6 reference cycles of a source stalling.
- R5: On a declared fault, only the faulty source's bit of `rst_req_o` goes high, in the same cycle its `fault_o` bit sets. It stays high for exactly 8 reference cycles, and `rst_req_o` is never more than one-hot.
- R6: After the reset pulse, all counters are cleared and monitoring restarts. A source that recovers draws no further pulse. A source that is still broken is declared again and draws another pulse.
- R7: Bits of `fault_o` stay set until `rst_n` is asserted.
- R8: When all three pairs are out of tolerance for 4 consecutive samples, `multi_fault_o` sets. No reset request is issued and `fault_o` is left unchanged.
- R9: `multi_fault_o` stays set until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for comparison and control |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| src_clk | input | 3 | The three redundant clock sources |
| fault_o | output | 3 | Latched per-source fault flags |
| rst_req_o | output | 3 | Per-source reset request, one 8-cycle pulse per declared fault |
| multi_fault_o | output | 1 | Latched unresolvable-disagreement flag |

## Verification
Each result comes with a known latency. A stalled source's counter freezes at once, but its lag becomes visible only after the Gray register and the two synchronizer stages. The mismatch then has to repeat four times. `fault_o` and `rst_req_o` therefore change together, roughly eight or more reference cycles after the stall. The bench samples on falling edges. It checks for silence at six cycles and for the flag only after a long settling window. It measures every request pulse edge to edge against exactly eight cycles. Recovery and re-declaration are judged by pulse counts over a window of 300 reference cycles.

// File: rtl/cdm_pkg.sv
`timescale 1ns/1ps
package cdm_pkg;

  typedef enum logic [2:0] {
    VD_NONE  = 3'd0,
    VD_SRC0  = 3'd1,
    VD_SRC1  = 3'd2,
    VD_SRC2  = 3'd3,
    VD_MULTI = 3'd4
  } verdict_t;

  typedef enum logic [1:0] {
    MS_WATCH = 2'd0,
    MS_PULSE = 2'd1,
    MS_CLEAR = 2'd2
  } mon_state_t;

endpackage

// File: rtl/cdm_rst_sync.sv
`timescale 1ns/1ps
module cdm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_o = out_q;
endmodule

// File: rtl/cdm_tmr_counter.sv
`timescale 1ns/1ps
module cdm_tmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_async,
  output logic [CNT_W-1:0] gray_o
);
  localparam int NCOPY = 3;

  logic             clr_meta_q;
  logic             clr_q;
  logic [CNT_W-1:0] copy_q [NCOPY];
  logic [CNT_W-1:0] voted;
  logic [CNT_W-1:0] cnt_next;
  logic [CNT_W-1:0] gray_next;
  logic [CNT_W-1:0] gray_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_meta_q <= 1'b0;
      clr_q      <= 1'b0;
    end else begin
      clr_meta_q <= clr_async;
      clr_q      <= clr_meta_q;
    end
  end

  assign voted = (copy_q[0] & copy_q[1]) | (copy_q[0] & copy_q[2]) |
                 (copy_q[1] & copy_q[2]);

  always_comb begin
    if (clr_q) cnt_next = '0;
    else       cnt_next = voted + 1'b1;
    gray_next = cnt_next ^ (cnt_next >> 1);
  end

  for (genvar k = 0; k < NCOPY; k++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) copy_q[k] <= '0;
      else        copy_q[k] <= cnt_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gray_q <= '0;
    else        gray_q <= gray_next;
  end

  assign gray_o = gray_q;
endmodule

// File: rtl/cdm_gray_sync.sv
`timescale 1ns/1ps
module cdm_gray_sync #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] gray_i,
  output logic [CNT_W-1:0] bin_o
);
  logic [CNT_W-1:0] meta_q;
  logic [CNT_W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_i;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    bin_o[CNT_W-1] = sync_q[CNT_W-1];
    for (int b = CNT_W - 2; b >= 0; b--) begin
      bin_o[b] = bin_o[b+1] ^ sync_q[b];
    end
  end
endmodule

// File: rtl/cdm_judge.sv
`timescale 1ns/1ps
module cdm_judge
  import cdm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TOL   = 2
) (
  input  logic [CNT_W-1:0] view0,
  input  logic [CNT_W-1:0] view1,
  input  logic [CNT_W-1:0] view2,
  output verdict_t         verdict_o
);
  localparam logic [CNT_W-1:0] TOL_V = CNT_W'(TOL);

  function automatic logic apart(input logic [CNT_W-1:0] a,
                                 input logic [CNT_W-1:0] b);
    logic [CNT_W-1:0] fwd;
    logic [CNT_W-1:0] bwd;
    fwd = a - b;
    bwd = b - a;
    return (fwd > TOL_V) && (bwd > TOL_V);
  endfunction

  logic mm01, mm12, mm02;

  assign mm01 = apart(view0, view1);
  assign mm12 = apart(view1, view2);
  assign mm02 = apart(view0, view2);

  always_comb begin
    verdict_o = VD_NONE;
    if (mm01 && mm12 && mm02)       verdict_o = VD_MULTI;
    else if (mm01 && mm02 && !mm12) verdict_o = VD_SRC0;
    else if (mm01 && mm12 && !mm02) verdict_o = VD_SRC1;
    else if (mm02 && mm12 && !mm01) verdict_o = VD_SRC2;
  end
endmodule

// File: rtl/clk_divergence_monitor.sv
`timescale 1ns/1ps
module clk_divergence_monitor
  import cdm_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int TOL       = 2,
  parameter int PERSIST   = 4,
  parameter int PULSE_CYC = 8,
  parameter int CLEAR_CYC = 8
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic [2:0] src_clk,
  output logic [2:0] fault_o,
  output logic [2:0] rst_req_o,
  output logic       multi_fault_o
);
  localparam int NSRC   = 3;
  localparam int PC_W   = $clog2(PERSIST + 1);
  localparam int TM_MAX = (PULSE_CYC > CLEAR_CYC) ? PULSE_CYC : CLEAR_CYC;
  localparam int TM_W   = $clog2(TM_MAX + 1);
  localparam logic [PC_W-1:0] PERSIST_V   = PC_W'(PERSIST);
  localparam logic [TM_W-1:0] PULSE_LAST  = TM_W'(PULSE_CYC - 1);
  localparam logic [TM_W-1:0] CLEAR_LAST  = TM_W'(CLEAR_CYC - 1);

  logic             ref_rst_n;
  logic [CNT_W-1:0] view [NSRC];
  verdict_t         verdict;

  mon_state_t       state_q, state_n;
  logic [PC_W-1:0]  persist_q, persist_n;
  verdict_t         last_q, last_n;
  logic [TM_W-1:0]  timer_q, timer_n;
  logic [NSRC-1:0]  fault_q, fault_n;
  logic [NSRC-1:0]  req_q, req_n;
  logic             multi_q, multi_n;
  logic             clr_q, clr_n;

  cdm_rst_sync u_ref_rst (
    .clk     (ref_clk),
    .arst_n  (rst_n),
    .rst_n_o (ref_rst_n)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic             src_rst_n;
    logic [CNT_W-1:0] gray;

    cdm_rst_sync u_src_rst (
      .clk     (src_clk[s]),
      .arst_n  (rst_n),
      .rst_n_o (src_rst_n)
    );

    cdm_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (src_clk[s]),
      .rst_n     (src_rst_n),
      .clr_async (clr_q),
      .gray_o    (gray)
    );

    cdm_gray_sync #(.CNT_W(CNT_W)) u_sync (
      .clk    (ref_clk),
      .rst_n  (ref_rst_n),
      .gray_i (gray),
      .bin_o  (view[s])
    );
  end

  cdm_judge #(.CNT_W(CNT_W), .TOL(TOL)) u_judge (
    .view0     (view[0]),
    .view1     (view[1]),
    .view2     (view[2]),
    .verdict_o (verdict)
  );

  always_comb begin
    state_n   = state_q;
    persist_n = persist_q;
    last_n    = last_q;
    timer_n   = timer_q;
    fault_n   = fault_q;
    req_n     = req_q;
    multi_n   = multi_q;
    clr_n     = clr_q;
    unique case (state_q)
      MS_WATCH: begin
        if (verdict == VD_NONE)                               persist_n = '0;
        else if (verdict != last_q)                           persist_n = PC_W'(1);
        else if (persist_q != PERSIST_V)                      persist_n = persist_q + 1'b1;
        last_n = verdict;
        if (persist_n == PERSIST_V) begin
          if (verdict == VD_MULTI) begin
            multi_n = 1'b1;
          end else begin
            unique case (verdict)
              VD_SRC0: req_n = 3'b001;
              VD_SRC1: req_n = 3'b010;
              default: req_n = 3'b100;
            endcase
            fault_n = fault_q | req_n;
            state_n = MS_PULSE;
            timer_n = '0;
          end
        end
      end
      MS_PULSE: begin
        if (timer_q == PULSE_LAST) begin
          state_n = MS_CLEAR;
          timer_n = '0;
          req_n   = '0;
          clr_n   = 1'b1;
        end else begin
          timer_n = timer_q + 1'b1;
        end
      end
      default: begin
        if (timer_q == CLEAR_LAST) begin
          state_n   = MS_WATCH;
          timer_n   = '0;
          clr_n     = 1'b0;
          persist_n = '0;
          last_n    = VD_NONE;
        end else begin
          timer_n = timer_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      state_q   <= MS_WATCH;
      persist_q <= '0;
      last_q    <= VD_NONE;
      timer_q   <= '0;
      fault_q   <= '0;
      req_q     <= '0;
      multi_q   <= 1'b0;
      clr_q     <= 1'b0;
    end else begin
      state_q   <= state_n;
      persist_q <= persist_n;
      last_q    <= last_n;
      timer_q   <= timer_n;
      fault_q   <= fault_n;
      req_q     <= req_n;
      multi_q   <= multi_n;
      clr_q     <= clr_n;
    end
  end

  assign fault_o       = fault_q;
  assign rst_req_o     = req_q;
  assign multi_fault_o = multi_q;
endmodule

// File: rtl/clk_divergence_monitor_chk.sv
`timescale 1ns/1ps
module clk_divergence_monitor_chk #(
  parameter int PULSE_CYC = 8
) (
  input logic       ref_clk,
  input logic       rst_n,
  input logic [2:0] fault_o,
  input logic [2:0] rst_req_o,
  input logic       multi_fault_o
);
  logic [7:0] run_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)            run_q <= '0;
    else if (|rst_req_o)   run_q <= run_q + 1'b1;
    else                   run_q <= '0;
  end

  // R5
  req_onehot_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $onehot0(rst_req_o));

  // R5
  req_has_fault_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (rst_req_o & ~fault_o) == 3'b000);

  // R5
  req_not_too_long_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (|rst_req_o) |-> (run_q < 8'(PULSE_CYC)));

  // R5
  req_full_length_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(|rst_req_o) |-> (run_q == 8'(PULSE_CYC)));

  // R7
  fault_sticky_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    1'b1 |=> ((fault_o & $past(fault_o)) == $past(fault_o)));

  // R9
  multi_sticky_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $past(multi_fault_o) |-> multi_fault_o);

  // R8
  multi_no_req_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(multi_fault_o) |-> (rst_req_o == 3'b000));
endmodule

bind clk_divergence_monitor clk_divergence_monitor_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .ref_clk       (ref_clk),
  .rst_n         (rst_n),
  .fault_o       (fault_o),
  .rst_req_o     (rst_req_o),
  .multi_fault_o (multi_fault_o)
);

// File: tb/test_clk_divergence_monitor.sv
`timescale 1ns/1ps
module test_clk_divergence_monitor;

  logic       ref_clk;
  logic       rst_n;
  logic [2:0] src_clk;
  logic [2:0] fault_o;
  logic [2:0] rst_req_o;
  logic       multi_fault_o;

  int checks = 0;
  int errors = 0;

  logic [2:0] stop_m  = 3'b000;
  logic [2:0] fast_m  = 3'b000;
  logic       heal_en = 1'b0;
  int         epoch   = 0;
  logic [2:0] healed  = 3'b000;
  int         seen_epoch = 0;
  int         runlen [3] = '{0, 0, 0};
  int         npul   [3] = '{0, 0, 0};
  int         badlen = 0;

  typedef struct packed {
    logic [2:0] stop;
    logic [2:0] fast;
    logic       heal;
    logic [2:0] fault;
    logic       multi;
    logic [1:0] npulse;
  } vec_t;

  // npulse: 0 = none, 1 = exactly one on the faulty source, 2 = at least two
  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{3'b000, 3'b000, 1'b0, 3'b000, 1'b0, 2'd0},
    '{3'b001, 3'b000, 1'b1, 3'b001, 1'b0, 2'd1},
    '{3'b010, 3'b000, 1'b1, 3'b010, 1'b0, 2'd1},
    '{3'b100, 3'b000, 1'b0, 3'b100, 1'b0, 2'd2},
    '{3'b001, 3'b010, 1'b0, 3'b000, 1'b1, 2'd0},
    '{3'b000, 3'b100, 1'b1, 3'b100, 1'b0, 2'd1}
  };

  clk_divergence_monitor i_clk_divergence_monitor (
    .ref_clk       (ref_clk),
    .rst_n         (rst_n),
    .src_clk       (src_clk),
    .fault_o       (fault_o),
    .rst_req_o     (rst_req_o),
    .multi_fault_o (multi_fault_o)
  );

  initial begin
    ref_clk = 1'b0;
    forever #10 ref_clk = ~ref_clk;
  end

  for (genvar g = 0; g < 3; g++) begin : g_clk
    logic ck;
    initial begin
      ck = 1'b0;
      #(3 + 4 * g);
      forever begin
        if (!(stop_m[g] && !healed[g])) ck = ~ck;
        if (fast_m[g] && !healed[g]) #5;
        else #10;
      end
    end
    assign src_clk[g] = ck;
  end

  always @(negedge ref_clk) begin
    if (epoch != seen_epoch) begin
      healed     = 3'b000;
      seen_epoch = epoch;
    end
    for (int i = 0; i < 3; i++) begin
      if (!rst_n) begin
        runlen[i] = 0;
      end else if (rst_req_o[i]) begin
        runlen[i] = runlen[i] + 1;
        if (heal_en) healed[i] = 1'b1;
      end else if (runlen[i] != 0) begin
        npul[i] = npul[i] + 1;
        if (runlen[i] != 8) badlen = badlen + 1;
        runlen[i] = 0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic do_reset();
    @(posedge ref_clk); #2;
    rst_n = 1'b0;
    wait_neg(3);
    @(posedge ref_clk); #2;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base [3];
    int bad0;
    rst_n = 1'b0;
    wait_neg(4);
    // R1: outputs idle during reset
    chk("R1 reset fault", {29'd0, fault_o}, 32'd0);
    chk("R1 reset req", {29'd0, rst_req_o}, 32'd0);
    chk("R1 reset multi", {31'd0, multi_fault_o}, 32'd0);
    @(posedge ref_clk); #2;
    rst_n = 1'b1;
    wait_neg(3);
    chk("R1 after release", {28'd0, multi_fault_o, fault_o | rst_req_o}, 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      epoch++;
      heal_en = VECS[v].heal;
      stop_m  = 3'b000;
      fast_m  = 3'b000;
      do_reset();
      wait_neg(30);
      for (int i = 0; i < 3; i++) base[i] = npul[i];
      bad0 = badlen;
      @(posedge ref_clk); #2;
      stop_m = VECS[v].stop;
      fast_m = VECS[v].fast;
      wait_neg(300);
      // R2 R3 R8: flags per vector
      chk($sformatf("R3 vec%0d fault", v), {29'd0, fault_o}, {29'd0, VECS[v].fault});
      chk($sformatf("R8 vec%0d multi", v), {31'd0, multi_fault_o}, {31'd0, VECS[v].multi});
      chk($sformatf("R5 vec%0d pulse length", v), badlen - bad0, 32'd0);
      for (int i = 0; i < 3; i++) begin
        int got;
        got = npul[i] - base[i];
        if (VECS[v].fault[i]) begin
          // R6: one pulse when healed, repeat pulses when still broken
          if (VECS[v].npulse == 2'd2)
            chk($sformatf("R6 vec%0d src%0d repeat", v, i), (got >= 2) ? 1 : 0, 1);
          else
            chk($sformatf("R6 vec%0d src%0d single", v, i), got, 1);
        end else begin
          chk($sformatf("R2 R8 vec%0d src%0d no pulse", v, i), got, 0);
        end
      end
      // R9: multi still latched with disagreement present
      if (VECS[v].multi) begin
        wait_neg(20);
        chk($sformatf("R9 vec%0d multi held", v), {31'd0, multi_fault_o}, 32'd1);
      end
    end

    // R4: persistence window after a stall
    epoch++;
    heal_en = 1'b1;
    stop_m  = 3'b000;
    fast_m  = 3'b000;
    do_reset();
    wait_neg(40);
    @(posedge ref_clk); #2;
    stop_m = 3'b010;
    wait_neg(6);
    chk("R4 no early fault", {29'd0, fault_o | rst_req_o}, 32'd0);
    wait_neg(40);
    chk("R4 fault after persistence", {29'd0, fault_o}, 32'd2);

    // R7: flag kept after recovery, cleared only by reset
    wait_neg(100);
    chk("R7 fault held", {29'd0, fault_o}, 32'd2);
    @(posedge ref_clk); #2;
    rst_n = 1'b0;
    wait_neg(2);
    chk("R7 reset clears", {28'd0, multi_fault_o, fault_o}, 32'd0);
    @(posedge ref_clk); #2;
    rst_n = 1'b1;
    wait_neg(10);
    chk("R1 idle after reset", {28'd0, multi_fault_o, fault_o | rst_req_o}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule